// File: doc/BRIEF.md
# Complementary Output-Compare Channel with Dead-Time

This block is a single timer channel in output-compare mode. It takes the running counter value from an external time base and compares it against a compare value that software loads one byte at a time. The compare value first lands in a staging register. It then moves to an active register, and only the active register is compared. A control input can defer that move until the next update event. Without it, the move happens on the following clock.

A three-bit behaviour selector turns each equality, or the magnitude relation in the two PWM styles, into a registered reference waveform. An external clear line can pull that waveform low. A dead-time stage splits the reference into a main output and a complementary output, and holds off each rising edge by a programmable number of clocks. A final gating stage applies per-output enables, per-output polarity and a master enable. It also applies two off-state selects that choose between driving the inactive level and releasing the output to zero.

Top module: `oc_dt_channel`

## Requirements
- R1: Byte writes load only the staging register. The active compare value follows it one clock after the staging register changes, provided the transfer is allowed.
- R2: While `preload_en_i` is 1, the active register changes only on a clock where `upd_i` is 1. While `preload_en_i` is 0, it reloads on every clock.
- R3: A high-byte write (`wr_hi_i`) sets a write-pending flag and a low-byte write (`wr_lo_i`) clears it. The low byte wins if both arrive together. While the flag is set, no transfer takes place, even with `upd_i` at 1.
- R4: `match_o` is 1 in exactly the cycles where `cnt_i` equals the active compare value, with no register in between.
- R5: `mode_i[2:0]` selects the next reference: 0 holds, 1 sets on match, 2 clears on match, 3 toggles on match, 4 forces 0, 5 forces 1, 6 gives `cnt_i < compare`, 7 gives `cnt_i >= compare`. `mode_i[3]` has no effect.
- R6: When `clr_en_i` and `ext_clr_i` are both 1, the next reference is 0 whatever the mode. `ext_clr_i` alone has no effect.
- R7: `ref_o` is registered: it reflects the mode, match and clear inputs sampled at the previous rising clock edge. It is 0 after reset.
- R8: The main dead-timed signal rises `dt_i` clocks after `ref_o` rises. The complementary one rises `dt_i` clocks after `ref_o` falls. Both fall in the same cycle as the reference edge, so they are never both 1. With `dt_i` = 0 they follow the reference directly.
- R9: A reference pulse lasting fewer than `dt_i` clocks produces no pulse on the corresponding dead-timed signal.
- R10: With `moe_i` = 1 and an output's enable at 1, that output equals its dead-timed signal XOR its polarity bit.
- R11: With `moe_i` = 1 and an output's enable at 0, that output is its polarity bit if `off_run_sel_i` = 1, else 0.
- R12: With `moe_i` = 0, each output is its polarity bit if `off_idle_sel_i` = 1, else 0. The reference and the dead-time stage have no effect on it.
- R13: After reset, the staging and active registers are 0, the write-pending flag is clear and the reference is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Counter value from the time base |
| upd_i | input | 1 | Update event strobe |
| wr_hi_i | input | 1 | Write strobe for the compare high byte |
| wr_lo_i | input | 1 | Write strobe for the compare low byte |
| wr_data_i | input | 8 | Byte write data |
| preload_en_i | input | 1 | Defer the transfer to update events |
| mode_i | input | 4 | Reference behaviour selector, bit 3 unused |
| clr_en_i | input | 1 | Allow the external clear |
| ext_clr_i | input | 1 | External clear request |
| dt_i | input | 8 | Dead-time in clocks |
| main_en_i | input | 1 | Main output enable |
| comp_en_i | input | 1 | Complementary output enable |
| main_pol_i | input | 1 | Main output polarity (1 inverts) |
| comp_pol_i | input | 1 | Complementary output polarity (1 inverts) |
| moe_i | input | 1 | Master output enable |
| off_idle_sel_i | input | 1 | Off-state select while the master enable is 0 |
| off_run_sel_i | input | 1 | Off-state select for a disabled output while the master enable is 1 |
| match_o | output | 1 | Counter equals the active compare value |
| ref_o | output | 1 | Registered reference waveform |
| out_main_o | output | 1 | Main output |
| out_comp_o | output | 1 | Complementary output |

## Verification
Two collisions are provoked on purpose. In the first, an update strobe lands on the same edge as a high-byte write. The bench expects the active register to take the staging value from before that write, and later strobes to be refused until the low byte arrives. In the second, the external clear is raised in the same cycle as a compare match in toggle mode. Here the reference must go low rather than toggle. In both cases a behavioural model steps through the edge and its result is compared with the ports in the following cycle.

// File: rtl/oc_dt_pkg.sv
package oc_dt_pkg;
  typedef enum logic [2:0] {
    OC_HOLD     = 3'd0,
    OC_SET_HIT  = 3'd1,
    OC_CLR_HIT  = 3'd2,
    OC_TGL_HIT  = 3'd3,
    OC_FORCE_LO = 3'd4,
    OC_FORCE_HI = 3'd5,
    OC_PWM_LT   = 3'd6,
    OC_PWM_GE   = 3'd7
  } oc_mode_e;

  localparam int unsigned OUT_MAIN = 0;
  localparam int unsigned OUT_COMP = 1;
  localparam int unsigned NUM_OUTS = 2;
endpackage

// File: rtl/oc_ccr_regs.sv
module oc_ccr_regs #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 2,
  localparam int unsigned VAL_W    = BYTE_W * NUM_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              preload_en_i,
  input  logic              upd_i,
  output logic [VAL_W-1:0]  shadow_o
);
  logic [VAL_W-1:0]     stage_q, shadow_q;
  logic                 wip_q;
  logic                 xfer;
  logic [NUM_BYTES-1:0] lane_we;

  // lowest lane takes the low strobe, highest lane the high strobe
  always_comb begin
    lane_we = '0;
    lane_we[0] = wr_lo_i;
    lane_we[NUM_BYTES-1] = lane_we[NUM_BYTES-1] | wr_hi_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      for (int b = 0; b < NUM_BYTES; b++) begin
        if (lane_we[b]) stage_q[b*BYTE_W +: BYTE_W] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wip_q <= 1'b0;
    else if (wr_lo_i) wip_q <= 1'b0;
    else if (wr_hi_i) wip_q <= 1'b1;
  end

  assign xfer = !wip_q && (!preload_en_i || upd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shadow_q <= '0;
    else if (xfer) shadow_q <= stage_q;
  end

  assign shadow_o = shadow_q;

  AST_DEFER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preload_en_i && !upd_i) |=> $stable(shadow_o)); // R2
  AST_PENDING_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i) |=> ##1 $stable(shadow_o) || $past(wr_lo_i)); // R3
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_dt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] shadow_i,
  input  logic [3:0]       mode_i,
  input  logic             clr_en_i,
  input  logic             ext_clr_i,
  output logic             match_o,
  output logic             ref_o
);
  oc_mode_e mode;
  logic     ref_q, ref_d, clr_req;

  assign mode    = oc_mode_e'(mode_i[2:0]);
  assign match_o = (cnt_i == shadow_i);
  assign clr_req = clr_en_i && ext_clr_i;

  always_comb begin
    ref_d = ref_q;
    unique case (mode)
      OC_HOLD:     ref_d = ref_q;
      OC_SET_HIT:  if (match_o) ref_d = 1'b1;
      OC_CLR_HIT:  if (match_o) ref_d = 1'b0;
      OC_TGL_HIT:  if (match_o) ref_d = !ref_q;
      OC_FORCE_LO: ref_d = 1'b0;
      OC_FORCE_HI: ref_d = 1'b1;
      OC_PWM_LT:   ref_d = (cnt_i < shadow_i);
      OC_PWM_GE:   ref_d = (cnt_i >= shadow_i);
      default:     ref_d = ref_q;
    endcase
    if (clr_req) ref_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_d;
  end

  assign ref_o = ref_q;

  AST_CLEAR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && ext_clr_i) |=> !ref_o); // R6
  AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2:0] == 3'd3 && match_o && !(clr_en_i && ext_clr_i)) |=> (ref_o != $past(ref_o))); // R5
  AST_HOLD_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2:0] == 3'd0 && !(clr_en_i && ext_clr_i)) |=> $stable(ref_o)); // R5
endmodule

// File: rtl/oc_deadtime.sv
module oc_deadtime #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            main_o,
  output logic            comp_o
);
  logic            ref_prev_q, edge_seen, elapsed;
  logic [DT_W-1:0] wait_q;

  assign edge_seen = (ref_i != ref_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_prev_q <= 1'b0;
      wait_q     <= '0;
    end else begin
      ref_prev_q <= ref_i;
      if (edge_seen)         wait_q <= (dt_i == '0) ? '0 : dt_i - 1'b1;
      else if (wait_q != '0) wait_q <= wait_q - 1'b1;
    end
  end

  // first cycle after a reference edge counts as elapsed only for zero dead-time
  assign elapsed = edge_seen ? (dt_i == '0) : (wait_q == '0);
  assign main_o  =  ref_i && elapsed;
  assign comp_o  = !ref_i && elapsed;

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_o && comp_o)); // R8
  AST_MAIN_AFTER_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(main_o) && dt_i != '0) |-> $past(ref_i)); // R8
  AST_COMP_AFTER_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(comp_o) && dt_i != '0) |-> !$past(ref_i)); // R8
endmodule

// File: rtl/oc_out_gate.sv
module oc_out_gate
  import oc_dt_pkg::*;
(
  input  logic [NUM_OUTS-1:0] sig_i,
  input  logic [NUM_OUTS-1:0] en_i,
  input  logic [NUM_OUTS-1:0] pol_i,
  input  logic                moe_i,
  input  logic                off_idle_sel_i,
  input  logic                off_run_sel_i,
  output logic [NUM_OUTS-1:0] out_o
);
  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_out
    logic live, off_drive;
    assign live      = moe_i && en_i[i];
    assign off_drive = moe_i ? off_run_sel_i : off_idle_sel_i;
    // disabled path: constant zero replaces the dead-timed signal, then polarity if driven
    assign out_o[i]  = live ? (sig_i[i] ^ pol_i[i]) : (off_drive && pol_i[i]);
  end
endmodule

// File: rtl/oc_dt_channel.sv
module oc_dt_channel
  import oc_dt_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DT_W   = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              upd_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              preload_en_i,
  input  logic [3:0]        mode_i,
  input  logic              clr_en_i,
  input  logic              ext_clr_i,
  input  logic [DT_W-1:0]   dt_i,
  input  logic              main_en_i,
  input  logic              comp_en_i,
  input  logic              main_pol_i,
  input  logic              comp_pol_i,
  input  logic              moe_i,
  input  logic              off_idle_sel_i,
  input  logic              off_run_sel_i,
  output logic              match_o,
  output logic              ref_o,
  output logic              out_main_o,
  output logic              out_comp_o
);
  logic [CNT_W-1:0]    shadow;
  logic                ref_w, dt_main, dt_comp;
  logic [NUM_OUTS-1:0] gate_sig, gate_en, gate_pol, gate_out;

  oc_ccr_regs #(.BYTE_W(BYTE_W), .NUM_BYTES(2)) u_ccr (
    .clk_i, .rst_ni, .wr_hi_i, .wr_lo_i, .wr_data_i,
    .preload_en_i, .upd_i, .shadow_o(shadow)
  );

  oc_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk_i, .rst_ni, .cnt_i, .shadow_i(shadow), .mode_i,
    .clr_en_i, .ext_clr_i, .match_o, .ref_o(ref_w)
  );

  oc_deadtime #(.DT_W(DT_W)) u_dt (
    .clk_i, .rst_ni, .ref_i(ref_w), .dt_i,
    .main_o(dt_main), .comp_o(dt_comp)
  );

  always_comb begin
    gate_sig = '0; gate_en = '0; gate_pol = '0;
    gate_sig[OUT_MAIN] = dt_main;    gate_sig[OUT_COMP] = dt_comp;
    gate_en[OUT_MAIN]  = main_en_i;  gate_en[OUT_COMP]  = comp_en_i;
    gate_pol[OUT_MAIN] = main_pol_i; gate_pol[OUT_COMP] = comp_pol_i;
  end

  oc_out_gate u_gate (
    .sig_i(gate_sig), .en_i(gate_en), .pol_i(gate_pol),
    .moe_i, .off_idle_sel_i, .off_run_sel_i, .out_o(gate_out)
  );

  assign ref_o      = ref_w;
  assign out_main_o = gate_out[OUT_MAIN];
  assign out_comp_o = gate_out[OUT_COMP];

  AST_IDLE_IGNORES_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!moe_i && !off_idle_sel_i) |-> (!out_main_o && !out_comp_o)); // R12
endmodule

// File: tb/oc_dt_channel_tb.sv
module oc_dt_channel_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic upd = 0, wr_hi = 0, wr_lo = 0, pre_en = 0, clr_en = 0, ext_clr = 0;
  logic [7:0] data = '0, dt = '0;
  logic [3:0] mode = '0;
  logic main_en = 0, comp_en = 0, main_pol = 0, comp_pol = 0, moe = 0, idle_sel = 0, run_sel = 0;
  logic match_o, ref_o, out_main_o, out_comp_o;
  int checks = 0, errs = 0;

  always #4 clk = ~clk;

  oc_dt_channel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .upd_i(upd), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo),
    .wr_data_i(data), .preload_en_i(pre_en), .mode_i(mode), .clr_en_i(clr_en), .ext_clr_i(ext_clr),
    .dt_i(dt), .main_en_i(main_en), .comp_en_i(comp_en), .main_pol_i(main_pol), .comp_pol_i(comp_pol),
    .moe_i(moe), .off_idle_sel_i(idle_sel), .off_run_sel_i(run_sel),
    .match_o(match_o), .ref_o(ref_o), .out_main_o(out_main_o), .out_comp_o(out_comp_o)
  );

  // behavioural model state
  int m_stage, m_act, m_run;
  bit m_wip, m_ref;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage = 0; m_act = 0; m_wip = 0; m_ref = 0; m_run = 1000;
    end else begin : step
      int n_act, n_stage; bit n_wip, n_ref, hit;
      hit = (int'(cnt) == m_act);
      n_act = (!m_wip && (!pre_en || upd)) ? m_stage : m_act;
      n_stage = m_stage; n_wip = m_wip;
      if (wr_hi) begin n_stage = (n_stage % 256) + int'(data) * 256; n_wip = 1; end
      if (wr_lo) begin n_stage = (n_stage / 256) * 256 + int'(data); n_wip = 0; end
      case (mode % 8)
        0: n_ref = m_ref;
        1: n_ref = hit ? 1'b1 : m_ref;
        2: n_ref = hit ? 1'b0 : m_ref;
        3: n_ref = hit ? !m_ref : m_ref;
        4: n_ref = 0;
        5: n_ref = 1;
        6: n_ref = int'(cnt) < m_act;
        default: n_ref = int'(cnt) >= m_act;
      endcase
      if (clr_en && ext_clr) n_ref = 0;
      m_run = (n_ref != m_ref) ? 0 : ((m_run < 1000) ? m_run + 1 : 1000);
      m_act = n_act; m_stage = n_stage; m_wip = n_wip; m_ref = n_ref;
    end
  end

  function automatic bit gate(bit s, bit en, bit pol);
    if (moe) return en ? (s ^ pol) : (run_sel ? pol : 1'b0);
    return idle_sel ? pol : 1'b0;
  endfunction

  task automatic chk(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("R4", "match", match_o, int'(cnt) == m_act);
      chk("R5", "ref", ref_o, m_ref);
      chk("R8", "main", out_main_o, gate(m_ref && m_run >= int'(dt), main_en, main_pol));
      chk("R8", "comp", out_comp_o, gate(!m_ref && m_run >= int'(dt), comp_en, comp_pol));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr_byte(bit hi, logic [7:0] v);
    wr_hi = hi; wr_lo = !hi; data = v;
    cyc(1);
    wr_hi = 0; wr_lo = 0;
  endtask

  task automatic run_cnt(int n, int per);
    for (int i = 0; i < n; i++) begin
      cyc(1);
      cnt = 16'((int'(cnt) + 1) % per);
    end
  endtask

  initial begin
    #(64'd8 * 200000);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R13", "ref in reset", ref_o, 1'b0);
    chk("R13", "match at zero", match_o, 1'b1);
    chk("R12", "idle low", out_main_o, 1'b0);
    rst_n = 1;
    cyc(2);
    chk("R13", "ref after reset", ref_o, 1'b0);

    // R1: immediate path, one clock from staging to active
    cnt = 16'd5;
    wr_byte(1, 8'h00); wr_byte(0, 8'h05);
    chk("R1", "not yet active", match_o, 1'b0);
    cyc(1);
    chk("R1", "active after a clock", match_o, 1'b1);

    // R2: deferred transfer
    pre_en = 1;
    wr_byte(0, 8'h09);
    cyc(3);
    chk("R2", "old value kept", match_o, 1'b1);
    cnt = 16'd9;
    cyc(1);
    chk("R2", "new value not active", match_o, 1'b0);
    upd = 1; cyc(1); upd = 0;
    chk("R2", "active after update", match_o, 1'b1);

    // R3: update collides with high-byte write, then is refused while pending
    wr_hi = 1; data = 8'h01; upd = 1; cyc(1); wr_hi = 0; upd = 0;
    chk("R3", "update took old staging", match_o, 1'b1);
    upd = 1; cyc(1); upd = 0;
    chk("R3", "update refused while pending", match_o, 1'b1);
    wr_byte(0, 8'h00);
    upd = 1; cyc(1); upd = 0;
    chk("R3", "old value gone", match_o, 1'b0);
    cnt = 16'h0100; cyc(1);
    chk("R3", "both bytes active", match_o, 1'b1);

    // R5: all modes with a free-running counter, including bit 3 set
    pre_en = 0; moe = 1; main_en = 1; comp_en = 1; dt = 8'd2;
    wr_byte(1, 8'h00); wr_byte(0, 8'h06);
    cnt = '0;
    for (int md = 0; md < 10; md++) begin
      mode = (md < 8) ? 4'(md) : ((md == 8) ? 4'b1110 : 4'b1011);
      run_cnt(30, 12);
    end

    // R7: registered reference
    mode = 4'd5; cyc(3);
    mode = 4'd4;
    chk("R7", "ref not yet low", ref_o, 1'b1);
    cyc(1);
    chk("R7", "ref low after edge", ref_o, 1'b0);

    // R6: clear priority, clear ignored without enable, clear on a toggle match
    mode = 4'd5; cyc(2);
    ext_clr = 1; cyc(1);
    chk("R6", "clear ignored without enable", ref_o, 1'b1);
    clr_en = 1; cyc(1);
    chk("R6", "forced low", ref_o, 1'b0);
    ext_clr = 0; cyc(1);
    chk("R6", "released", ref_o, 1'b1);
    mode = 4'd3; cnt = 16'd6; ext_clr = 1; cyc(1);
    chk("R6", "clear beats toggle match", ref_o, 1'b0);
    ext_clr = 0; clr_en = 0; cnt = 16'd7;

    // R8: dead-time of 3 on both edges
    mode = 4'd4; cyc(20); dt = 8'd3;
    mode = 4'd5; cyc(1);
    chk("R8", "comp drops with ref", out_comp_o, 1'b0);
    cyc(2);
    chk("R8", "main held off", out_main_o, 1'b0);
    cyc(1);
    chk("R8", "main after 3", out_main_o, 1'b1);
    mode = 4'd4; cyc(1);
    chk("R8", "main drops with ref", out_main_o, 1'b0);
    cyc(2);
    chk("R8", "comp held off", out_comp_o, 1'b0);
    cyc(1);
    chk("R8", "comp after 3", out_comp_o, 1'b1);

    // R9: short pulses swallowed
    cyc(20);
    mode = 4'd5; cyc(1);
    chk("R9", "short high pulse c1", out_main_o, 1'b0);
    mode = 4'd4; cyc(1);
    chk("R9", "short high pulse c2", out_main_o, 1'b0);
    cyc(1);
    chk("R9", "short high pulse gone", out_main_o, 1'b0);
    cyc(20);
    mode = 4'd5; cyc(20);
    mode = 4'd4; cyc(1); mode = 4'd5; cyc(1);
    chk("R9", "short low pulse", out_comp_o, 1'b0);
    cyc(3);
    chk("R9", "comp stayed low", out_comp_o, 1'b0);

    // R8: zero dead-time follows directly
    cyc(20); dt = 8'd0;
    mode = 4'd4; cyc(1);
    chk("R8", "zero dt comp", out_comp_o, 1'b1);
    mode = 4'd6; cnt = '0; run_cnt(40, 9);

    // R10: polarity while running
    dt = 8'd1; main_pol = 1; run_cnt(30, 9);
    comp_pol = 1; main_pol = 0; run_cnt(30, 9);
    mode = 4'd5; cyc(10); comp_pol = 0; main_pol = 1; cyc(1);
    chk("R10", "inverted main", out_main_o, 1'b0);
    main_pol = 0; cyc(1);
    chk("R10", "plain main", out_main_o, 1'b1);

    // R11: disabled output while master enable is set
    main_en = 0; run_sel = 0; main_pol = 1; cyc(1);
    chk("R11", "released to zero", out_main_o, 1'b0);
    run_sel = 1; cyc(1);
    chk("R11", "driven inactive", out_main_o, 1'b1);
    comp_en = 0; comp_pol = 0; cyc(1);
    chk("R11", "comp inactive low", out_comp_o, 1'b0);

    // R12: master enable off
    main_en = 1; comp_en = 1; moe = 0; idle_sel = 1; comp_pol = 1; main_pol = 0; cyc(1);
    chk("R12", "comp idle level", out_comp_o, 1'b1);
    chk("R12", "main idle level", out_main_o, 1'b0);
    mode = 4'd6; run_cnt(20, 9);
    idle_sel = 0; cyc(1);
    chk("R12", "comp released", out_comp_o, 1'b0);
    run_cnt(20, 9);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule